// File: doc/BRIEF.md
# Display PHY Power-Up and Lock Sequencer

This block drives the reset and shutdown controls of a display serial-link PHY, and the power-up control of the host core that feeds it, whenever the link is switched on or off. An enable request first holds the core in reset. The block then waits for a separate configuration sequencer to report that PHY programming is finished.

After that it releases the PHY in three fixed stages:

1. the clock enable;
2. the shutdown release;
3. the reset release.

It then waits a settling time and polls the PHY status at fixed intervals, for a bounded number of polls. When the status reports lock, the block powers up the core, requests a high-speed clock lane and raises a ready flag. When every poll fails, it still powers up the core but raises a sticky timeout flag instead of ready.

A disable request clears every control in one cycle. All delays are parameters counted in system clock cycles: the stage gap, the settling time, the poll spacing and the poll count.

Top module: `phy_pwrup_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `phy_ctl`, `core_pwr`, `clk_hs_req`, `ready` and `timeout` are all zero.
- R2: An enable request accepted while disabled keeps `core_pwr` low and clears `timeout` in the next cycle. `phy_ctl` stays 000 for as long as `cfg_done` is low.
- R3: In the `phy_ctl` field, bit 2 is clock enable, bit 1 is reset release and bit 0 is shutdown release. In the cycle after `cfg_done` is sampled, `phy_ctl` becomes 100 and holds that value for GAP_CYC cycles. It then becomes 101 for GAP_CYC cycles, and then 111.
- R4: After `phy_ctl` reaches 111, the block waits SETTLE_CYC cycles. It then samples the status once at the next clock edge, and again every POLL_CYC cycles. A poll succeeds if `pll_lock` or `clk_stop` is high, and a failed poll leaves `core_pwr` low.
- R5: In the cycle after a successful poll, `core_pwr`, `clk_hs_req` and `ready` become 1 and `timeout` stays 0.
- R6: After POLL_MAX consecutive failed polls, `core_pwr`, `clk_hs_req` and `timeout` become 1 and `ready` stays 0.
- R7: In the cycle after a disable request is accepted, `phy_ctl`, `core_pwr`, `clk_hs_req` and `ready` are all zero. `timeout` keeps its value until the next accepted enable.
- R8: An enable request while the block is not disabled has no effect, and a disable request while it is disabled has no effect. When both requests arrive in the same cycle, the disable takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Enable request pulse |
| dis_req | input | 1 | Disable request pulse |
| cfg_done | input | 1 | Configuration sequencer has finished |
| pll_lock | input | 1 | PHY status: PLL locked |
| clk_stop | input | 1 | PHY status: clock lane in stop state |
| phy_ctl | output | 3 | PHY controls {clock enable, reset release, shutdown release} |
| core_pwr | output | 1 | Core power-up (0 holds the core in reset) |
| clk_hs_req | output | 1 | High-speed clock-lane request |
| ready | output | 1 | Lock seen and core powered |
| timeout | output | 1 | Sticky: polls ran out without lock |

## Verification
The assertions assume the status inputs change only between clock edges and carry no X once reset is released. This matters because a rise of `ready` is traced back to the status values at the previous edge.

The assertions also assume the PHY control word is driven only by this block's sequence. Only then can every change of `phy_ctl` be checked as one legal stage step or as a clear-down to zero.

The stimulus drives every input one time unit after a rising edge, and drives the status inputs as clean levels held across each poll edge. Enable and disable are always one-cycle pulses. The one case in which both requests arrive in the same cycle is deliberate.

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq #(
  parameter int GAP_CYC    = 100,
  parameter int SETTLE_CYC = 100000,
  parameter int POLL_CYC   = 100,
  parameter int POLL_MAX   = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_req,
  input  logic       dis_req,
  input  logic       cfg_done,
  input  logic       pll_lock,
  input  logic       clk_stop,
  output logic [2:0] phy_ctl,
  output logic       core_pwr,
  output logic       clk_hs_req,
  output logic       ready,
  output logic       timeout
);

  localparam int M1 = (GAP_CYC > POLL_CYC) ? GAP_CYC : POLL_CYC;
  localparam int MC = (SETTLE_CYC > M1) ? SETTLE_CYC : M1;
  localparam int CW = $clog2(MC + 1);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam logic [CW-1:0] GAP_LD  = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] SET_LD  = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] POLL_LD = CW'(POLL_CYC - 1);
  localparam logic [PW-1:0] LAST_P  = PW'(POLL_MAX - 1);

  typedef enum logic [2:0] {S_OFF, S_CFG, S_CLK, S_UNSHUT, S_SETTLE, S_POLL, S_ON} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] polls;

  wire locked = pll_lock | clk_stop;
  wire cnt_z  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_OFF;
      cnt        <= '0;
      polls      <= '0;
      phy_ctl    <= 3'b000;
      core_pwr   <= 1'b0;
      clk_hs_req <= 1'b0;
      ready      <= 1'b0;
      timeout    <= 1'b0;
    end else if (dis_req && st != S_OFF) begin
      st         <= S_OFF;
      cnt        <= '0;
      phy_ctl    <= 3'b000;
      core_pwr   <= 1'b0;
      clk_hs_req <= 1'b0;
      ready      <= 1'b0;
    end else begin
      case (st)
        S_OFF: if (en_req) begin
          st       <= S_CFG;
          timeout  <= 1'b0;
          core_pwr <= 1'b0;
        end
        S_CFG: if (cfg_done) begin
          st      <= S_CLK;
          phy_ctl <= 3'b100;
          cnt     <= GAP_LD;
        end
        S_CLK: if (cnt_z) begin
          st      <= S_UNSHUT;
          phy_ctl <= 3'b101;
          cnt     <= GAP_LD;
        end else cnt <= cnt - 1'b1;
        S_UNSHUT: if (cnt_z) begin
          st      <= S_SETTLE;
          phy_ctl <= 3'b111;
          cnt     <= SET_LD;
        end else cnt <= cnt - 1'b1;
        S_SETTLE: if (cnt_z) begin
          st    <= S_POLL;
          polls <= '0;
        end else cnt <= cnt - 1'b1;
        S_POLL: if (cnt_z) begin
          if (locked) begin
            st         <= S_ON;
            core_pwr   <= 1'b1;
            clk_hs_req <= 1'b1;
            ready      <= 1'b1;
          end else if (polls == LAST_P) begin
            st         <= S_ON;
            core_pwr   <= 1'b1;
            clk_hs_req <= 1'b1;
            timeout    <= 1'b1;
          end else begin
            polls <= polls + 1'b1;
            cnt   <= POLL_LD;
          end
        end else cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/phy_pwrup_seq_chk.sv
module phy_pwrup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pll_lock,
  input logic       clk_stop,
  input logic [2:0] phy_ctl,
  input logic       core_pwr,
  input logic       clk_hs_req,
  input logic       ready,
  input logic       timeout
);

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    phy_ctl inside {3'b000, 3'b100, 3'b101, 3'b111}); // R3

  AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_ctl != $past(phy_ctl) && phy_ctl != 3'b000) |->
      (($past(phy_ctl) == 3'b000 && phy_ctl == 3'b100) ||
       ($past(phy_ctl) == 3'b100 && phy_ctl == 3'b101) ||
       ($past(phy_ctl) == 3'b101 && phy_ctl == 3'b111))); // R3

  AST_CORE_AFTER_PHY: assert property (@(posedge clk) disable iff (!rst_n)
    core_pwr |-> phy_ctl == 3'b111); // R5

  AST_READY_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(pll_lock | clk_stop)); // R4

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (core_pwr && clk_hs_req && !timeout)); // R6

  AST_DROP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_ctl[2]) |-> (phy_ctl == 3'b000 && !core_pwr && !clk_hs_req && !ready)); // R7

endmodule

bind phy_pwrup_seq phy_pwrup_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .clk_stop(clk_stop),
  .phy_ctl(phy_ctl), .core_pwr(core_pwr), .clk_hs_req(clk_hs_req),
  .ready(ready), .timeout(timeout));

// File: tb/sim_phy_pwrup_seq.sv
module sim_phy_pwrup_seq;
  localparam int G = 3, S = 10, P = 2, N = 5;

  logic clk = 0, rst_n = 0, en_req = 0, dis_req = 0, cfg_done = 0;
  logic pll_lock = 0, clk_stop = 0;
  logic [2:0] phy_ctl;
  logic core_pwr, clk_hs_req, ready, timeout;

  phy_pwrup_seq #(.GAP_CYC(G), .SETTLE_CYC(S), .POLL_CYC(P), .POLL_MAX(N)) u0 (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .cfg_done(cfg_done), .pll_lock(pll_lock), .clk_stop(clk_stop),
    .phy_ctl(phy_ctl), .core_pwr(core_pwr), .clk_hs_req(clk_hs_req),
    .ready(ready), .timeout(timeout));

  always #5 clk = ~clk;

  // row: {status before switch {stop,lock}, status after switch, switch poll index}
  localparam logic [7:0] VEC [6] = '{
    {2'b01, 2'b01, 4'd0},
    {2'b10, 2'b10, 4'd0},
    {2'b00, 2'b11, 4'd2},
    {2'b00, 2'b01, 4'd4},
    {2'b00, 2'b00, 4'd0},
    {2'b00, 2'b10, 4'd5}
  };

  int n_chk = 0, n_fail = 0;

  // observed word: {ready, timeout, clk_hs_req, core_pwr, phy_ctl}
  function automatic logic [6:0] obs();
    return {ready, timeout, clk_hs_req, core_pwr, phy_ctl};
  endfunction

  task automatic check(input string tag, input logic [6:0] exp);
    n_chk++;
    if (obs() !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, obs(), exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic bring_up(input logic [1:0] bef, input logic [1:0] aft, input int sw);
    int ok_at;
    ok_at = -1;
    for (int k = 0; k < N; k++)
      if (ok_at < 0 && ((k >= sw) ? aft : bef) != 2'b00) ok_at = k;
    {clk_stop, pll_lock} = bef;
    en_req = 1; tick(); en_req = 0;
    check("R2 core held and timeout cleared", 7'b0000000);
    for (int i = 0; i < 3; i++) begin tick(); check("R2 waits for cfg_done", 7'b0000000); end
    cfg_done = 1; tick(); cfg_done = 0;
    for (int i = 0; i < G; i++) begin check("R3 stage clock enable", 7'b0000100); tick(); end
    for (int i = 0; i < G; i++) begin check("R3 stage shutdown release", 7'b0000101); tick(); end
    check("R3 full release", 7'b0000111);
    for (int i = 0; i < S; i++) begin tick(); check("R4 settle no power-up", 7'b0000111); end
    for (int k = 0; k < N; k++) begin
      {clk_stop, pll_lock} = (k >= sw) ? aft : bef;
      tick();
      if (k == ok_at) begin
        check("R5 lock powers core", 7'b1011111);
        return;
      end else if (k == N - 1) begin
        check("R6 poll timeout", 7'b0111111);
        return;
      end else begin
        check("R4 failed poll", 7'b0000111);
        for (int j = 0; j < P - 1; j++) begin tick(); check("R4 poll gap", 7'b0000111); end
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [6:0] fin;
    repeat (3) tick();
    check("R1 in reset", 7'b0000000);
    rst_n = 1; tick();
    check("R1 after reset", 7'b0000000);

    dis_req = 1; tick(); dis_req = 0;
    check("R8 disable while disabled", 7'b0000000);

    for (int r = 0; r < 6; r++) begin
      v = VEC[r];
      bring_up(v[7:6], v[5:4], int'(v[3:0]));
      fin = obs();
      en_req = 1; tick(); en_req = 0;
      check("R8 enable while on ignored", fin);
      dis_req = 1; tick(); dis_req = 0;
      check("R7 disable clears, timeout sticky", {1'b0, fin[5], 5'b00000});
      tick();
      check("R7 stays off", {1'b0, fin[5], 5'b00000});
    end

    {clk_stop, pll_lock} = 2'b01;
    en_req = 1; tick(); en_req = 0;
    cfg_done = 1; tick(); cfg_done = 0;
    check("R3 mid sequence stage", 7'b0000100);
    en_req = 1; dis_req = 1; tick(); en_req = 0; dis_req = 0;
    check("R8 disable wins over enable", 7'b0000000);
    for (int i = 0; i < G + S + 4; i++) tick();
    check("R7 remains off after abort", 7'b0000000);

    bring_up(2'b01, 2'b01, 0);
    check("R5 re-enable after abort", 7'b1011111);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule